// File: doc/BRIEF.md
# Center-Aligned PWM Generator

This block produces one symmetric pulse-width-modulated output. The timebase is a 12-bit counter that ramps up and then back down. It advances only on ticks from a power-of-two prescaler, so one output cycle lasts twice the programmed period, measured in ticks. The output pulse sits at the low end of the ramp and is symmetric about the turn-around point at zero.

Software-facing write ports place new period and duty values in shadow registers. Those values reach the counter and comparator only after a load request has been made and the counter has then reached a cycle boundary. A pending-load indicator shows whether a request is still waiting, and a one-clock flag marks each boundary. Both let surrounding logic line up its updates with the waveform.

Top module: `cpwm_gen`

## Requirements
- R1: Let P be the active period (P > 0). Counter ticks then step through the values 0, 1, …, P−1 on the rising ramp and P, P−1, …, 1 on the falling ramp. After that the counter returns to 0, so consecutive boundaries are 2·P ticks apart.
- R2: Let D be the active duty. In each cycle the output is high for 2·min(D, P) ticks. It is high on the rising ramp while the count is below D, and on the falling ramp while the count is at most D. The output is registered and follows the counter by one clock.
- R3: A tick occurs every 2^S clocks, where S is the 3-bit `presc_sel` value (0 to 7 select divide ratios 1 to 128).
- R4: Writes to period or duty that are not followed by a load request do not change the waveform, and they do not set the pending indicator.
- R5: A load request sets `load_pending` on the next clock. The shadow values become active at the first boundary after that clock, and `load_pending` clears there. A request made in the same clock as a boundary stays pending until the next boundary.
- R6: `cycle_start` is high for exactly one clock per boundary, in the clock after the tick that returns the counter to 0.
- R7: A duty of 0 holds the output low. A duty of at least the period, and nonzero, holds it high.
- R8: A period of 0 makes every tick a boundary. The output is then high whenever the duty is nonzero.
- R9: While reset is asserted, the counter clears to 0 on the rising ramp, the output, the flag and the pending indicator are low, and both shadow and active registers take the parameter defaults (period 100, duty 50).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Prescaler exponent: tick every 2^presc_sel clocks |
| period_we | input | 1 | Write enable for the period shadow register |
| period_wdata | input | 12 | Period value to write |
| duty_we | input | 1 | Write enable for the duty shadow register |
| duty_wdata | input | 12 | Duty value to write |
| load_req | input | 1 | Request transfer of shadow values at the next boundary |
| pwm_out | output | 1 | PWM waveform |
| cycle_start | output | 1 | One-clock boundary flag |
| load_pending | output | 1 | A load request is waiting for a boundary |

## Verification
Most faults in this block reach the ports within one output cycle. A wrong counter turn-around or a wrong compare direction changes either the spacing of `cycle_start` or the count of high clocks between two flags. A faulty prescaler mask scales both of those counts by the wrong power of two. A shadow or active register that updates at the wrong time is slower to show. It appears as a cycle length that changes in the middle of a cycle, or as a pending indicator that stays high or clears without a flag. The bench therefore measures whole boundary-to-boundary intervals and compares them with the 2·P·2^S and 2·min(D,P)·2^S figures.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

    localparam int CNT_W     = 12;
    localparam int SEL_W     = 3;
    localparam int PRE_CNT_W = (1 << SEL_W) - 1;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
    } pwm_cfg_t;

    // Low S bits set: tick when the free-running count has them all set.
    function automatic logic [PRE_CNT_W-1:0] presc_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_CNT_W; i++) begin
            if (i < int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Asymmetric compare so each ramp contributes exactly D high ticks.
    function automatic logic pwm_level(input ramp_dir_e dir,
                                       input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] duty);
        if (dir == RAMP_UP) return (cnt < duty);
        else                return (cnt <= duty);
    endfunction

endpackage

// File: rtl/cpwm_prescaler.sv
`timescale 1ns/1ps
module cpwm_prescaler
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_CNT_W-1:0] pre_q;
    logic [PRE_CNT_W-1:0] mask;

    always_comb begin
        mask = presc_mask(sel);
        tick = ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/cpwm_cfg_regs.sv
`timescale 1ns/1ps
module cpwm_cfg_regs
    import cpwm_pkg::*;
#(
    parameter logic [CNT_W-1:0] DEF_PERIOD = 12'd100,
    parameter logic [CNT_W-1:0] DEF_DUTY   = 12'd50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             load_req,
    input  logic             boundary,
    output pwm_cfg_t         act_cfg,
    output logic             pending
);

    localparam pwm_cfg_t DEF_CFG = '{period: DEF_PERIOD, duty: DEF_DUTY};

    pwm_cfg_t shadow_q;
    pwm_cfg_t act_q;
    logic     pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= DEF_CFG;
        end else begin
            if (period_we) shadow_q.period <= period_wdata;
            if (duty_we)   shadow_q.duty   <= duty_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= DEF_CFG;
            pend_q <= 1'b0;
        end else begin
            if (boundary && pend_q) act_q <= shadow_q;
            pend_q <= load_req | (pend_q & ~boundary);
        end
    end

    assign act_cfg = act_q;
    assign pending = pend_q;

endmodule

// File: rtl/cpwm_updown_cnt.sv
`timescale 1ns/1ps
module cpwm_updown_cnt
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output ramp_dir_e        dir,
    output logic             boundary
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    ramp_dir_e        dir_q, dir_d;

    always_comb begin
        cnt_d    = cnt_q;
        dir_d    = dir_q;
        boundary = 1'b0;
        if (tick) begin
            if (period == '0) begin
                cnt_d    = '0;
                dir_d    = RAMP_UP;
                boundary = 1'b1;
            end else if (dir_q == RAMP_UP) begin
                cnt_d = cnt_q + 1'b1;
                dir_d = (cnt_d >= period) ? RAMP_DOWN : RAMP_UP;
            end else begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_d == '0) begin
                    dir_d    = RAMP_UP;
                    boundary = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= RAMP_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt = cnt_q;
    assign dir = dir_q;

endmodule

// File: rtl/cpwm_gen.sv
`timescale 1ns/1ps
module cpwm_gen
    import cpwm_pkg::*;
#(
    parameter logic [CNT_W-1:0] DEF_PERIOD = 12'd100,
    parameter logic [CNT_W-1:0] DEF_DUTY   = 12'd50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             load_req,
    output logic             pwm_out,
    output logic             cycle_start,
    output logic             load_pending
);

    logic             tick;
    logic             boundary;
    pwm_cfg_t         act_cfg;
    logic [CNT_W-1:0] cnt_q;
    ramp_dir_e        dir_q;
    logic             pwm_q;
    logic             flag_q;

    cpwm_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (presc_sel),
        .tick (tick)
    );

    cpwm_cfg_regs #(
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_DUTY   (DEF_DUTY)
    ) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .duty_we      (duty_we),
        .duty_wdata   (duty_wdata),
        .load_req     (load_req),
        .boundary     (boundary),
        .act_cfg      (act_cfg),
        .pending      (load_pending)
    );

    cpwm_updown_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .period   (act_cfg.period),
        .cnt      (cnt_q),
        .dir      (dir_q),
        .boundary (boundary)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pwm_q  <= pwm_level(dir_q, cnt_q, act_cfg.duty);
            flag_q <= boundary;
        end
    end

    assign pwm_out     = pwm_q;
    assign cycle_start = flag_q;

endmodule

// File: rtl/cpwm_chk.sv
`timescale 1ns/1ps
module cpwm_chk
    import cpwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load_req,
    input logic             load_pending,
    input logic             cycle_start,
    input logic             pwm_out,
    input logic [SEL_W-1:0] presc_sel,
    input logic [CNT_W-1:0] period_act,
    input logic [CNT_W-1:0] duty_act,
    input logic [CNT_W-1:0] cnt
);

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        load_req |=> load_pending);

    // R5
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cycle_start && !$past(load_req)) |-> !load_pending);

    // R4
    act_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cycle_start) |-> ($stable(period_act) && $stable(duty_act)));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= period_act);

    // R7
    low_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(duty_act == '0)) |-> !pwm_out);

    // R7
    full_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(duty_act != '0 && duty_act >= period_act)) |-> pwm_out);

    // R6
    flag_once_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cycle_start && presc_sel != '0 && $past(presc_sel) != '0)
            |=> !cycle_start);

endmodule

bind cpwm_gen cpwm_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_req     (load_req),
    .load_pending (load_pending),
    .cycle_start  (cycle_start),
    .pwm_out      (pwm_out),
    .presc_sel    (presc_sel),
    .period_act   (act_cfg.period),
    .duty_act     (act_cfg.duty),
    .cnt          (cnt_q)
);

// File: tb/tb_cpwm_gen.sv
`timescale 1ns/1ps
module tb_cpwm_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  presc_sel = 3'd0;
    logic        period_we = 1'b0;
    logic [11:0] period_wdata = '0;
    logic        duty_we = 1'b0;
    logic [11:0] duty_wdata = '0;
    logic        load_req = 1'b0;
    logic        pwm_out;
    logic        cycle_start;
    logic        load_pending;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cpwm_gen dut (
        .clk          (clk),
        .rst          (rst),
        .presc_sel    (presc_sel),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .duty_we      (duty_we),
        .duty_wdata   (duty_wdata),
        .load_req     (load_req),
        .pwm_out      (pwm_out),
        .cycle_start  (cycle_start),
        .load_pending (load_pending)
    );

    // {presc_sel, period, duty}
    localparam int NV = 7;
    localparam logic [26:0] VECS [NV] = '{
        {3'd0, 12'd10, 12'd3},
        {3'd1, 12'd10, 12'd5},
        {3'd2, 12'd6,  12'd6},
        {3'd0, 12'd8,  12'd0},
        {3'd3, 12'd4,  12'd9},
        {3'd0, 12'd1,  12'd1},
        {3'd1, 12'd5,  12'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_flag();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cycle_start && g < 5000);
    endtask

    // Starts on a negedge where cycle_start is high, ends on the next one.
    task automatic measure(output int n, output int h, output int flag_after);
        n = 0; h = 0;
        do begin
            n++;
            if (pwm_out) h++;
            @(negedge clk);
            if (n == 1) flag_after = int'(cycle_start);
        end while (!cycle_start && n < 10000);
    endtask

    task automatic load_cfg(input logic [11:0] p, input logic [11:0] d);
        period_we = 1'b1; period_wdata = p;
        duty_we   = 1'b1; duty_wdata   = d;
        load_req  = 1'b1;
        @(negedge clk);
        period_we = 1'b0; duty_we = 1'b0; load_req = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, h, fa;
        repeat (5) @(negedge clk);
        // R9: reset state
        check(pwm_out == 1'b0, "R9 pwm low in reset", int'(pwm_out), 0);
        check(cycle_start == 1'b0, "R9 flag low in reset", int'(cycle_start), 0);
        check(load_pending == 1'b0, "R9 pending low in reset", int'(load_pending), 0);
        rst = 1'b0;

        // R9: defaults active after reset (period 100, duty 50, divide 1)
        wait_flag();
        wait_flag();
        measure(n, h, fa);
        check(n == 200, "R9 default cycle length", n, 200);
        check(h == 100, "R9 default high time", h, 100);

        // Table: R1 R2 R3 R6 R7 R5
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  s;
            logic [11:0] p, d;
            int div, en, eh;
            {s, p, d} = VECS[i];
            div = 1 << s;
            en  = 2 * int'(p) * div;
            eh  = 2 * ((d < p) ? int'(d) : int'(p)) * div;
            presc_sel = s;
            load_cfg(p, d);
            check(load_pending == 1'b1, "R5 pending after request", int'(load_pending), 1);
            wait_flag();
            check(load_pending == 1'b0, "R5 pending cleared at boundary", int'(load_pending), 0);
            wait_flag();
            measure(n, h, fa);
            check(n == en, "R1 R3 cycle length", n, en);
            check(h == eh, "R2 R7 high time", h, eh);
            if (s != 3'd0) check(fa == 0, "R6 flag lasts one clock", fa, 0);
        end

        // R5: request mid-cycle leaves current cycle at old length
        presc_sel = 3'd0;
        load_cfg(12'd10, 12'd3);
        wait_flag();
        wait_flag();
        n = 0;
        repeat (5) begin n++; @(negedge clk); end
        n++;
        load_cfg(12'd20, 12'd7);
        check(load_pending == 1'b1, "R5 pending mid-cycle", int'(load_pending), 1);
        while (!cycle_start && n < 10000) begin n++; @(negedge clk); end
        check(n == 20, "R5 old period kept until boundary", n, 20);
        wait_flag();
        measure(n, h, fa);
        check(n == 40, "R5 new period after boundary", n, 40);
        check(h == 14, "R5 new duty after boundary", h, 14);

        // R4: shadow writes without a load request
        period_we = 1'b1; period_wdata = 12'd5;
        duty_we   = 1'b1; duty_wdata   = 12'd1;
        @(negedge clk);
        period_we = 1'b0; duty_we = 1'b0;
        check(load_pending == 1'b0, "R4 no pending without request", int'(load_pending), 0);
        wait_flag();
        measure(n, h, fa);
        check(n == 40, "R4 period unchanged", n, 40);
        check(h == 14, "R4 duty unchanged", h, 14);

        // R8: period zero, nonzero duty
        load_cfg(12'd0, 12'd5);
        wait_flag();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            check(pwm_out == 1'b1, "R8 output high at period 0", int'(pwm_out), 1);
            check(cycle_start == 1'b1, "R8 boundary every tick", int'(cycle_start), 1);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule